// File: doc/BRIEF.md
# Mailbox Message Reassembling Receiver

This block drains an inbound mailbox ring of 32-bit slots and rebuilds one logical message out of one or more fragments. Each fragment begins with a header slot that carries a 9-bit byte length and a "final fragment" flag. The payload follows in whole slots, with the last slot only partly used. The receiver turns the slots into a byte stream with valid/ready flow control. Within each slot the byte order is little-endian. The receiver keeps a running byte budget that the caller supplies when it starts a reception.

A reception starts with a one-cycle `start` pulse. It ends in one of four ways: a final fragment is delivered, the budget runs out, a fragment too long for the remaining budget is refused, or a zero-length fragment arrives. When a non-final fragment has been consumed and the ring holds nothing more, the receiver pulses a doorbell so the peer knows to refill the ring. At the end the block pulses `done` and presents two results with it: the total bytes delivered, and a success flag. The ring storage itself lies outside the block. It is reached through a fill count, a head-slot data word and a pop strobe.

The controller walks through seven named states:
- IDLE waits for `start`.
- HDR waits for a filled slot and pops the header.
- EVAL decodes the header and checks its length.
- SLOT pops the next payload slot.
- EMIT streams that slot's bytes.
- NEXT decides between a doorbell, another header, or the end.
- DONE presents the result for one cycle.

The transitions are:
- IDLE→HDR on start with a non-zero budget, and IDLE→DONE on start with a zero budget.
- HDR→EVAL on a pop.
- EVAL→SLOT for an accepted fragment, and EVAL→NEXT for a refused or empty one.
- SLOT→EMIT on a pop, and SLOT→NEXT when no payload remains.
- EMIT→SLOT after the last byte of the slot.
- NEXT→HDR to continue, and NEXT→DONE to stop.
- DONE→IDLE.

Top module: `mbx_rx_reassembler`

## Requirements
- R1: After `start` with a non-zero budget, the block pops a slot only while `ring_fill` is non-zero. The first slot popped is a header: its bits 24:16 give the fragment length in bytes and bit 31 marks the final fragment.
- R2: An accepted fragment of length L pops ceil(L/4) payload slots. It emits exactly L bytes, lowest byte of each slot first. From a trailing partial slot only the low L mod 4 bytes are emitted.
- R3: A fragment whose length exceeds the remaining budget emits no bytes and ends the reception with `ok` low.
- R4: A zero-length fragment sets `zero_warn`, which holds until the next `start`. The reception then ends with `ok` low.
- R5: After an accepted, non-final fragment, with budget left, the block reads the next header. The bytes of successive fragments are emitted back to back in ring order.
- R6: After a non-final fragment (accepted or not), `doorbell` pulses for one cycle if `ring_fill` is zero at that point. It stays low otherwise and outside a reception.
- R7: `done` is a one-cycle pulse. With it, `total_bytes` equals the sum of accepted fragment lengths. `ok` is high only if the last header was final, its fragment was non-empty and accepted, and `peer_ready` is high.
- R8: A non-final fragment that uses up exactly the remaining budget ends the reception with `ok` low, and `total_bytes` never exceeds the budget.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged on the next cycle.
- R10: `start` with a zero budget gives `done` with `total_bytes` zero and `ok` low, and pops no slot. While idle, `out_valid`, `slot_rd` and `doorbell` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a reception (ignored while busy) |
| budget | input | BUDGET_W | Byte budget for the reception, sampled with `start` |
| ring_fill | input | FILL_W | Number of filled slots in the inbound ring |
| ring_data | input | 32 | Contents of the ring's head slot |
| slot_rd | output | 1 | Pop strobe; the head slot is consumed at the clock edge |
| peer_ready | input | 1 | Peer health indication, judged when the reception ends |
| out_valid | output | 1 | Output byte is valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream accepts the byte |
| doorbell | output | 1 | One-cycle request for the peer to send more |
| busy | output | 1 | A reception is in progress |
| done | output | 1 | One-cycle end-of-reception pulse |
| ok | output | 1 | Success, valid with `done` |
| total_bytes | output | BUDGET_W | Bytes delivered in this reception, valid with `done` |
| zero_warn | output | 1 | A zero-length fragment was seen in this reception |

## Verification
Some properties are checked by assertions on every cycle:
- the stream holds its byte under backpressure;
- no slot is popped from an empty ring;
- the doorbell pulses only while the ring is empty and only inside a reception;
- `done` lasts one cycle;
- a successful result implies a healthy peer;
- the reported total never exceeds the latched budget.

Other properties depend on the content of a whole message, so only the bench scenarios can show them. These are the byte order and partial-slot trimming, the concatenation of fragments, and the stopping rules: an oversized, empty or budget-exhausting fragment. The bench also covers whether a doorbell appears when the peer withholds the next fragment and stays absent when the ring is already stocked.

// File: rtl/mbx_rx_pkg.sv
package mbx_rx_pkg;

    // Slot geometry of the inbound ring
    localparam int SLOT_W     = 32;
    localparam int SLOT_BYTES = SLOT_W / 8;

    // Header layout: the peer encodes these positions, so they are fixed
    localparam int HDR_LEN_LSB  = 16;
    localparam int HDR_LEN_W    = 9;
    localparam int HDR_LAST_BIT = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_EVAL,
        ST_SLOT,
        ST_EMIT,
        ST_NEXT,
        ST_DONE
    } rx_state_e;

endpackage

// File: rtl/mbx_hdr_decode.sv
module mbx_hdr_decode
    import mbx_rx_pkg::*;
#(
    parameter int BUDGET_W = 16
) (
    input  logic [SLOT_W-1:0]    hdr,
    input  logic [BUDGET_W-1:0]  left,
    output logic [HDR_LEN_W-1:0] frag_len,
    output logic                 frag_last,
    output logic                 frag_too_big,
    output logic                 frag_empty
);

    // Common width for the length versus budget comparison
    localparam int CMP_W = (BUDGET_W > HDR_LEN_W) ? BUDGET_W : HDR_LEN_W;

    logic [CMP_W-1:0] len_ext;
    logic [CMP_W-1:0] left_ext;

    always_comb begin
        frag_len     = hdr[HDR_LEN_LSB +: HDR_LEN_W];
        frag_last    = hdr[HDR_LAST_BIT];
        len_ext      = CMP_W'(frag_len);
        left_ext     = CMP_W'(left);
        frag_too_big = (len_ext > left_ext);
        frag_empty   = (frag_len == '0);
    end

endmodule

// File: rtl/mbx_slot_unpack.sv
module mbx_slot_unpack
    import mbx_rx_pkg::*;
#(
    parameter int CNT_W = $clog2(SLOT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SLOT_W-1:0] load_data,
    input  logic [CNT_W-1:0]  load_count,
    input  logic              take,
    output logic [7:0]        byte_out,
    output logic              avail,
    output logic              last
);

    logic [SLOT_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;

    // Shift out from the low end: little-endian within the slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            shreg_q <= load_data;
            cnt_q   <= load_count;
        end else if (take && (cnt_q != '0)) begin
            shreg_q <= shreg_q >> 8;
            cnt_q   <= cnt_q - CNT_W'(1);
        end
    end

    always_comb begin
        byte_out = shreg_q[7:0];
        avail    = (cnt_q != '0);
        last     = (cnt_q == CNT_W'(1));
    end

endmodule

// File: rtl/mbx_rx_reassembler.sv
module mbx_rx_reassembler
    import mbx_rx_pkg::*;
#(
    parameter int BUDGET_W = 16,
    parameter int FILL_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [BUDGET_W-1:0] budget,
    input  logic [FILL_W-1:0]   ring_fill,
    input  logic [SLOT_W-1:0]   ring_data,
    output logic                slot_rd,
    input  logic                peer_ready,
    output logic                out_valid,
    output logic [7:0]          out_data,
    input  logic                out_ready,
    output logic                doorbell,
    output logic                busy,
    output logic                done,
    output logic                ok,
    output logic [BUDGET_W-1:0] total_bytes,
    output logic                zero_warn
);

    localparam int CNT_W = $clog2(SLOT_BYTES + 1);

    rx_state_e state_q, state_d;

    logic [SLOT_W-1:0]    hdr_q;
    logic [BUDGET_W-1:0]  left_q;
    logic [BUDGET_W-1:0]  total_q;
    logic [HDR_LEN_W-1:0] rem_q;
    logic                 got_q;
    logic                 warn_q;

    logic [HDR_LEN_W-1:0] frag_len;
    logic                 frag_last;
    logic                 frag_too_big;
    logic                 frag_empty;

    logic [CNT_W-1:0]     slot_nb;
    logic                 ring_has;
    logic                 pop_hdr;
    logic                 pop_slot;
    logic                 fire;
    logic                 more;
    logic                 unp_avail;
    logic                 unp_last;
    logic [7:0]           unp_byte;

    // Header field extraction and budget comparison
    mbx_hdr_decode #(
        .BUDGET_W(BUDGET_W)
    ) u_dec (
        .hdr         (hdr_q),
        .left        (left_q),
        .frag_len    (frag_len),
        .frag_last   (frag_last),
        .frag_too_big(frag_too_big),
        .frag_empty  (frag_empty)
    );

    // Slot to byte serialiser
    mbx_slot_unpack #(
        .CNT_W(CNT_W)
    ) u_unp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pop_slot),
        .load_data (ring_data),
        .load_count(slot_nb),
        .take      (fire),
        .byte_out  (unp_byte),
        .avail     (unp_avail),
        .last      (unp_last)
    );

    // Helper terms shared by the next-state and datapath logic
    always_comb begin
        ring_has = (ring_fill != '0);
        if (rem_q >= HDR_LEN_W'(SLOT_BYTES)) begin
            slot_nb = CNT_W'(SLOT_BYTES);
        end else begin
            slot_nb = CNT_W'(rem_q);
        end
        pop_hdr  = (state_q == ST_HDR) && ring_has;
        pop_slot = (state_q == ST_SLOT) && (rem_q != '0) && ring_has;
        fire     = (state_q == ST_EMIT) && unp_avail && out_ready;
        more     = got_q && !frag_last && (left_q != '0);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (budget == '0) ? ST_DONE : ST_HDR;
                end
            end
            ST_HDR: begin
                if (pop_hdr) begin
                    state_d = ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (frag_too_big || frag_empty) begin
                    state_d = ST_NEXT;
                end else begin
                    state_d = ST_SLOT;
                end
            end
            ST_SLOT: begin
                if (rem_q == '0) begin
                    state_d = ST_NEXT;
                end else if (pop_slot) begin
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (fire && unp_last) begin
                    state_d = ST_SLOT;
                end
            end
            ST_NEXT: begin
                state_d = more ? ST_HDR : ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Datapath registers: header, budget, count, fragment progress, warning
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q   <= '0;
            left_q  <= '0;
            total_q <= '0;
            rem_q   <= '0;
            got_q   <= 1'b0;
            warn_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        hdr_q   <= '0;
                        left_q  <= budget;
                        total_q <= '0;
                        rem_q   <= '0;
                        got_q   <= 1'b0;
                        warn_q  <= 1'b0;
                    end
                end
                ST_HDR: begin
                    if (pop_hdr) begin
                        hdr_q <= ring_data;
                    end
                end
                ST_EVAL: begin
                    if (frag_too_big) begin
                        got_q <= 1'b0;
                        rem_q <= '0;
                    end else if (frag_empty) begin
                        got_q  <= 1'b0;
                        rem_q  <= '0;
                        warn_q <= 1'b1;
                    end else begin
                        got_q <= 1'b1;
                        rem_q <= frag_len;
                    end
                end
                ST_SLOT: begin
                    if (pop_slot) begin
                        rem_q <= rem_q - HDR_LEN_W'(slot_nb);
                    end
                end
                ST_EMIT: begin
                    if (fire) begin
                        left_q  <= left_q - BUDGET_W'(1);
                        total_q <= total_q + BUDGET_W'(1);
                    end
                end
                ST_NEXT, ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs, decoded from the current state
    always_comb begin
        slot_rd     = 1'b0;
        out_valid   = 1'b0;
        out_data    = unp_byte;
        doorbell    = 1'b0;
        busy        = 1'b1;
        done        = 1'b0;
        ok          = 1'b0;
        total_bytes = total_q;
        zero_warn   = warn_q;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_HDR:  slot_rd = pop_hdr;
            ST_EVAL: begin
            end
            ST_SLOT: slot_rd = pop_slot;
            ST_EMIT: out_valid = unp_avail;
            ST_NEXT: doorbell = !frag_last && !ring_has;
            ST_DONE: begin
                done = 1'b1;
                ok   = got_q && frag_last && peer_ready;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/mbx_rx_checker.sv
module mbx_rx_checker
    import mbx_rx_pkg::*;
#(
    parameter int BUDGET_W = 16,
    parameter int FILL_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [BUDGET_W-1:0] budget,
    input logic [FILL_W-1:0]   ring_fill,
    input logic                slot_rd,
    input logic                peer_ready,
    input logic                out_valid,
    input logic [7:0]          out_data,
    input logic                out_ready,
    input logic                doorbell,
    input logic                busy,
    input logic                done,
    input logic                ok,
    input logic [BUDGET_W-1:0] total_bytes
);

    logic [BUDGET_W-1:0] bud_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bud_q <= '0;
        end else if (start && !busy) begin
            bud_q <= budget;
        end
    end

    // R1: never pop an empty ring
    p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_rd |-> (ring_fill != '0));

    // R6: doorbell only with an empty ring, for a single cycle
    p_bell_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |-> (ring_fill == '0) && busy);

    p_bell_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |=> !doorbell);

    // R7: done lasts one cycle; success needs a healthy peer
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ok_peer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (done && peer_ready));

    // R8: delivered count bounded by the budget given at start
    p_budget_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (total_bytes <= bud_q));

    // R9: stream holds under backpressure
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10: quiet while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid && !slot_rd && !doorbell));

endmodule

bind mbx_rx_reassembler mbx_rx_checker #(
    .BUDGET_W(BUDGET_W),
    .FILL_W  (FILL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .budget     (budget),
    .ring_fill  (ring_fill),
    .slot_rd    (slot_rd),
    .peer_ready (peer_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready),
    .doorbell   (doorbell),
    .busy       (busy),
    .done       (done),
    .ok         (ok),
    .total_bytes(total_bytes)
);

// File: tb/sim_mbx_rx_reassembler.sv
module sim_mbx_rx_reassembler;

    localparam int BW = 16;
    localparam int FW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [BW-1:0] budget = '0;
    logic [FW-1:0] ring_fill = '0;
    logic [31:0]   ring_data = '0;
    logic          slot_rd;
    logic          peer_ready = 1'b1;
    logic          out_valid;
    logic [7:0]    out_data;
    logic          out_ready = 1'b1;
    logic          doorbell;
    logic          busy;
    logic          done;
    logic          ok;
    logic [BW-1:0] total_bytes;
    logic          zero_warn;

    always #10 clk = ~clk;

    mbx_rx_reassembler #(.BUDGET_W(BW), .FILL_W(FW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .budget(budget),
        .ring_fill(ring_fill), .ring_data(ring_data), .slot_rd(slot_rd),
        .peer_ready(peer_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .doorbell(doorbell), .busy(busy), .done(done),
        .ok(ok), .total_bytes(total_bytes), .zero_warn(zero_warn)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int bell_cnt = 0;
    int exp_bells = 0;
    int done_cnt = 0;
    bit bp_mode = 1'b0;
    bit flush_req = 1'b0;

    int unsigned ring_q[$];
    byte unsigned exp_q[$];

    // Reference model state
    int m_left, m_total;
    bit m_stop, m_cmpl, m_nz, m_warn;

    task automatic chk(bit cond, string req, string what, int act, int expv);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Ring model: updates with the clock edge, as storage would
    always @(posedge clk) begin
        if (flush_req) ring_q.delete();
        else if (slot_rd && ring_q.size() > 0) ring_q.delete(0);
        ring_fill <= FW'(ring_q.size());
        ring_data <= (ring_q.size() > 0) ? ring_q[0] : 32'h0;
    end

    // Downstream ready pattern
    always @(negedge clk) begin
        cyc++;
        out_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
    end

    // Per-cycle comparison against the reference model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected byte", int'(out_data), -1);
                end else begin
                    chk(out_data == exp_q[0], "R2", "byte value",
                        int'(out_data), int'(exp_q[0]));
                    exp_q.delete(0);
                end
            end
            if (doorbell) bell_cnt++;
            if (done) begin
                chk(int'(total_bytes) == m_total, "R7", "total_bytes",
                    int'(total_bytes), m_total);
                chk(ok == (m_cmpl && m_nz && peer_ready), "R7", "ok",
                    int'(ok), int'(m_cmpl && m_nz && peer_ready));
                chk(zero_warn == m_warn, "R4", "zero_warn",
                    int'(zero_warn), int'(m_warn));
                chk(exp_q.size() == 0, "R5", "bytes missing", exp_q.size(), 0);
                chk(bell_cnt == exp_bells, "R6", "doorbell count",
                    bell_cnt, exp_bells);
                done_cnt++;
            end
        end
    end

    // Watchdog
    always @(negedge clk) begin
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic begin_run(int b, bit peer, int bells);
        m_left = b; m_total = 0; m_stop = (b == 0);
        m_cmpl = 0; m_nz = 0; m_warn = 0;
        exp_q.delete();
        bell_cnt = 0;
        exp_bells = bells;
        peer_ready = peer;
    endtask

    // Push one fragment into the ring and apply the receive rules to it
    task automatic push_frag(int len, bit cmpl, int base);
        int unsigned hdr, w;
        int nslots;
        hdr = (int'(cmpl) << 31) | ((len & 'h1ff) << 16) | 32'h0000_0A05;
        ring_q.push_back(hdr);
        nslots = (len + 3) / 4;
        for (int s = 0; s < nslots; s++) begin
            w = 0;
            for (int b = 0; b < 4; b++) begin
                if (s * 4 + b < len) w |= ((base + s * 4 + b) & 'hff) << (8 * b);
                else w |= (32'hE0 + b) << (8 * b);
            end
            ring_q.push_back(w);
        end
        if (!m_stop) begin
            if (len > m_left) begin
                m_stop = 1; m_nz = 0;
            end else if (len == 0) begin
                m_warn = 1; m_stop = 1; m_nz = 0; m_cmpl = cmpl;
            end else begin
                for (int i = 0; i < len; i++) exp_q.push_back(8'((base + i) & 'hff));
                m_left -= len; m_total += len; m_nz = 1; m_cmpl = cmpl;
                if (cmpl || m_left == 0) m_stop = 1;
            end
        end
    endtask

    task automatic fire(int b);
        @(negedge clk);
        start = 1'b1;
        budget = BW'(b);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run(int d0);
        while (done_cnt == d0) @(negedge clk);
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        // Reset state (R10)
        chk(!busy && !out_valid && !slot_rd && !done && !doorbell, "R10",
            "reset outputs quiet", int'({busy, out_valid, slot_rd, done, doorbell}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2: single final fragment with trailing partial slot
        begin_run(64, 1, 0);
        push_frag(6, 1, 'h11);
        d0 = done_cnt; fire(64); finish_run(d0);

        // R5 R9: two stocked fragments under backpressure
        bp_mode = 1'b1;
        begin_run(64, 1, 0);
        push_frag(8, 0, 'h30);
        push_frag(3, 1, 'h50);
        d0 = done_cnt; fire(64); finish_run(d0);
        bp_mode = 1'b0;

        // R6: drained ring mid-message rings the doorbell; peer then refills
        begin_run(64, 1, 1);
        push_frag(4, 0, 'h60);
        d0 = done_cnt; fire(64);
        while (bell_cnt == 0) @(negedge clk);
        push_frag(5, 1, 'h70);
        finish_run(d0);

        // R3: first fragment larger than the budget
        begin_run(10, 1, 0);
        push_frag(20, 1, 'h80);
        d0 = done_cnt; fire(10); finish_run(d0);

        // R3 R5: second fragment exceeds what is left
        begin_run(10, 1, 0);
        push_frag(4, 0, 'h90);
        push_frag(12, 1, 'hA0);
        d0 = done_cnt; fire(10); finish_run(d0);

        // R4: zero-length final fragment
        begin_run(32, 1, 0);
        push_frag(0, 1, 0);
        d0 = done_cnt; fire(32); finish_run(d0);

        // R8: non-final fragment consumes the whole budget; ring empty, so bell
        begin_run(8, 1, 1);
        push_frag(8, 0, 'hB0);
        d0 = done_cnt; fire(8); finish_run(d0);

        // R8: final fragment exactly filling the budget succeeds
        begin_run(8, 1, 0);
        push_frag(8, 1, 'hC0);
        d0 = done_cnt; fire(8); finish_run(d0);

        // R7: peer not ready at the end spoils success
        begin_run(16, 0, 0);
        push_frag(2, 1, 'hD0);
        d0 = done_cnt; fire(16); finish_run(d0);
        peer_ready = 1'b1;

        // R10: zero budget pops nothing
        begin_run(0, 1, 0);
        push_frag(5, 1, 'hE0);
        d0 = done_cnt; fire(0);
        while (done_cnt == d0) @(negedge clk);
        @(negedge clk);
        chk(ring_q.size() == 3, "R10", "ring untouched", ring_q.size(), 3);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        @(negedge clk);

        // R4: warning cleared by the next start
        begin_run(16, 1, 0);
        push_frag(1, 1, 'h21);
        d0 = done_cnt; fire(16); finish_run(d0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule